// File: doc/BRIEF.md
# Viterbi Branch Metric Unit (rate 1/2, hard or soft input)

This block sits at the front of a Viterbi decoder for a rate 1/2 convolutional code. On each cycle with `in_valid` high it takes one received codeword of two symbols and computes a distance between that codeword and each of the four codewords the encoder could have sent (00, 01, 10, 11). The four distances leave a register one cycle later with `out_valid`, ready for an add-compare-select stage.

Each symbol is an unsigned integer of `SOFT_W` bits, ordered by confidence: 0 is the surest zero, `2^SOFT_W-1` is the surest one, and the values in between grade from zero to one. With `SOFT_W = 1` the same datapath is a plain Hamming-distance unit on hard bits. A symbol can be removed from the metric in two ways: by an erasure flag from the channel, or by a keep flag that is low at positions the transmitter punctured. A removed symbol adds nothing to any of the four metrics.

The input port may be wider than `SOFT_W` (`IN_W > SOFT_W`). A value above `2^SOFT_W-1` is then clamped to that maximum and reported on `range_err`.

Top module: `viterbi_bmu`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; metrics and `range_err` present that input's result in the same cycle.
- R2: For a present symbol of value v, its distance is v when the expected bit is 0 and (2^SOFT_W-1)-v when the expected bit is 1.
- R3: Metric index i holds the sum of the two symbol distances, where bit 1 of i is the expected bit for `sym0` and bit 0 of i is the expected bit for `sym1`; each metric is SOFT_W+1 bits wide and never exceeds 2*(2^SOFT_W-1).
- R4: When `erase[j]` is 1, symbol j (bit 0 for `sym0`, bit 1 for `sym1`) adds 0 to all four metrics.
- R5: When `keep[j]` is 0 (punctured position), symbol j adds 0 to all four metrics, exactly as an erasure does.
- R6: When `IN_W > SOFT_W`, a present symbol above 2^SOFT_W-1 is treated as 2^SOFT_W-1 and `range_err` is high with that input's result; `range_err` is low for all in-range or removed symbols, and always low when `IN_W == SOFT_W`.
- R7: In a cycle after `in_valid` was low, `out_valid` is low and the metrics keep their last values.
- R8: After synchronous active-low reset, `out_valid`, `range_err` and all metrics are 0.
- R9: For every result, metric 00 plus metric 11 equals metric 01 plus metric 10.
- R10: With `SOFT_W = IN_W = 1`, each metric is the Hamming distance (0 to 2) between the received bits and the expected pair, counting only present symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Codeword present this cycle |
| sym0 | input | IN_W | First received symbol |
| sym1 | input | IN_W | Second received symbol |
| erase | input | 2 | Erasure flags, bit j for symbol j |
| keep | input | 2 | Depuncture flags, 0 marks a punctured symbol |
| out_valid | output | 1 | Metrics valid |
| metrics | output | 4 x (SOFT_W+1) | Branch metrics, index = expected {sym0 bit, sym1 bit} |
| range_err | output | 1 | A present input symbol was above the soft range |

## Verification
The assertions take for granted that `erase`, `keep` and both symbols are known (not X) whenever `in_valid` is high, and that the range flag and bound properties reason only about cycles following a valid input after reset. The stimulus drives every control input to a defined value on every cycle, holds them at zero during reset, and sweeps all in-range soft pairs, all erase and keep combinations, and out-of-range values on both symbols including the widest port value. A second instance with one-bit symbols covers hard-decision operation with all bit pairs and masks.

// File: rtl/bmu_pkg.sv
// Shared constants for the branch metric unit.
// Assumes a rate 1/2 code: two symbols per codeword, four expected pairs.
package bmu_pkg;
    localparam int NSYM   = 2;
    localparam int NPAIRS = 4;

    // Metric word width for a given soft symbol width.
    function automatic int metric_width(input int soft_w);
        return soft_w + NSYM - 1;
    endfunction
endpackage

// File: rtl/bmu_sym_dist.sv
// Distance of one received symbol to an expected 0 and an expected 1.
// Clamps port values above the soft range when the port is wider than
// SOFT_W. A removed symbol (erased or punctured) yields zero distances.
// Assumes IN_W >= SOFT_W.
module bmu_sym_dist #(
    parameter int SOFT_W = 3,
    parameter int IN_W   = 4
) (
    input  logic [IN_W-1:0]   sym_i,
    input  logic              drop_i,
    output logic [SOFT_W-1:0] to_zero_o,
    output logic [SOFT_W-1:0] to_one_o,
    output logic              over_o
);
    localparam logic [SOFT_W-1:0] MAXV = '1;

    logic [SOFT_W-1:0] val;
    logic              over;

    generate
        if (IN_W > SOFT_W) begin : g_wide
            // Detect and clamp values beyond the soft range.
            assign over = (sym_i > {{(IN_W-SOFT_W){1'b0}}, MAXV});
            assign val  = over ? MAXV : sym_i[SOFT_W-1:0];
        end else begin : g_exact
            // Port matches the soft range: nothing can overflow.
            assign over = 1'b0;
            assign val  = sym_i[SOFT_W-1:0];
        end
    endgenerate

    // Confidence-ordered distances, zeroed for a removed symbol.
    always_comb begin
        if (drop_i) begin
            to_zero_o = '0;
            to_one_o  = '0;
        end else begin
            to_zero_o = val;
            to_one_o  = MAXV - val;
        end
        over_o = over & ~drop_i;
    end
endmodule

// File: rtl/bmu_pair_sum.sv
// Forms the four branch metrics from the per-symbol distances.
// Index bit 1 selects the expected bit of symbol 0, bit 0 that of symbol 1.
module bmu_pair_sum #(
    parameter int SOFT_W = 3,
    parameter int MW     = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]                      s0_zero_i,
    input  logic [SOFT_W-1:0]                      s0_one_i,
    input  logic [SOFT_W-1:0]                      s1_zero_i,
    input  logic [SOFT_W-1:0]                      s1_one_i,
    output logic [bmu_pkg::NPAIRS-1:0][MW-1:0]     sum_o
);
    for (genvar i = 0; i < bmu_pkg::NPAIRS; i++) begin : g_pair
        localparam int E0 = (i / 2) % 2;
        localparam int E1 = i % 2;
        logic [SOFT_W-1:0] da, db;
        // Pick each symbol's distance for this expected pair, then add.
        assign da = (E0 != 0) ? s0_one_i : s0_zero_i;
        assign db = (E1 != 0) ? s1_one_i : s1_zero_i;
        assign sum_o[i] = MW'(da) + MW'(db);
    end
endmodule

// File: rtl/viterbi_bmu.sv
// Branch metric unit for a rate 1/2 code with hard or soft symbols.
// One codeword per cycle in, four registered metrics out one cycle later.
// Assumes inputs are known whenever in_valid is high; IN_W >= SOFT_W.
module viterbi_bmu #(
    parameter int SOFT_W = 3,
    parameter int IN_W   = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [IN_W-1:0]                          sym0,
    input  logic [IN_W-1:0]                          sym1,
    input  logic [1:0]                               erase,
    input  logic [1:0]                               keep,
    output logic                                     out_valid,
    output logic [bmu_pkg::NPAIRS-1:0][SOFT_W:0]     metrics,
    output logic                                     range_err
);
    localparam int MW   = bmu_pkg::metric_width(SOFT_W);
    localparam int MAXI = (1 << SOFT_W) - 1;

    logic [1:0]              drop;
    logic [1:0]              over;
    logic [SOFT_W-1:0]       to_zero [2];
    logic [SOFT_W-1:0]       to_one  [2];
    logic [bmu_pkg::NPAIRS-1:0][MW-1:0] sum;

    assign drop = erase | ~keep;

    for (genvar j = 0; j < bmu_pkg::NSYM; j++) begin : g_sym
        bmu_sym_dist #(.SOFT_W(SOFT_W), .IN_W(IN_W)) u_dist (
            .sym_i     ((j == 0) ? sym0 : sym1),
            .drop_i    (drop[j]),
            .to_zero_o (to_zero[j]),
            .to_one_o  (to_one[j]),
            .over_o    (over[j])
        );
    end

    bmu_pair_sum #(.SOFT_W(SOFT_W), .MW(MW)) u_sum (
        .s0_zero_i (to_zero[0]),
        .s0_one_i  (to_one[0]),
        .s1_zero_i (to_zero[1]),
        .s1_one_i  (to_one[1]),
        .sum_o     (sum)
    );

    // Output register: valid always tracks input, data loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            metrics   <= '0;
            range_err <= 1'b0;
        end else begin
            out_valid <= in_valid;
            range_err <= in_valid & (|over);
            if (in_valid) metrics <= sum;
        end
    end

    // R1: one-cycle valid latency.
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7: no valid in, no valid out and metrics held.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(metrics)));
    // R4 / R5: both symbols removed gives all-zero metrics.
    a_r4_removed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && drop == 2'b11) |=> (metrics == '0 && !range_err));
    // R9: complementary pairs balance.
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((MW+1)'(metrics[0]) + (MW+1)'(metrics[3]) ==
                       (MW+1)'(metrics[1]) + (MW+1)'(metrics[2])));
    // R6: range flag appears only with a result.
    a_r6_flag_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> out_valid);

    // R3: every metric stays within twice the largest symbol distance.
    for (genvar k = 0; k < bmu_pkg::NPAIRS; k++) begin : g_bound
        a_r3_metric_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(metrics[k]) <= 2 * MAXI));
    end

    generate
        if (IN_W > SOFT_W) begin : g_rchk
            // R6: a present oversize symbol raises the flag next cycle.
            a_r6_oversize_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !drop[0] && int'(sym0) > MAXI) |=> range_err);
        end
    endgenerate
endmodule

// File: tb/tb_viterbi_bmu.sv
// Scoreboard bench: drivers push expected results, monitors compare them.
module tb_viterbi_bmu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // Soft instance (3-bit symbols, 4-bit port) and hard instance (1 bit).
    logic            s_iv = 0;
    logic [3:0]      s_s0 = 0, s_s1 = 0;
    logic [1:0]      s_er = 0, s_kp = 0;
    logic            s_ov, s_re;
    logic [3:0][3:0] s_m;

    logic            h_iv = 0;
    logic [0:0]      h_s0 = 0, h_s1 = 0;
    logic [1:0]      h_er = 0, h_kp = 0;
    logic            h_ov, h_re;
    logic [3:0][1:0] h_m;

    viterbi_bmu #(.SOFT_W(3), .IN_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .sym0(s_s0), .sym1(s_s1),
        .erase(s_er), .keep(s_kp), .out_valid(s_ov), .metrics(s_m), .range_err(s_re));

    viterbi_bmu #(.SOFT_W(1), .IN_W(1)) dut_hard (
        .clk(clk), .rst_n(rst_n), .in_valid(h_iv), .sym0(h_s0), .sym1(h_s1),
        .erase(h_er), .keep(h_kp), .out_valid(h_ov), .metrics(h_m), .range_err(h_re));

    typedef struct { int m[4]; bit flag; string req; } exp_t;
    exp_t qs[$];
    exp_t qh[$];
    int checks = 0;
    int errors = 0;
    int last_soft[4];
    bit s_pend = 0, h_pend = 0;
    bit done = 0;

    // Reference distance per the confidence ordering.
    function automatic int sdist(int v, int n, int e, bit drop);
        int maxv = (1 << n) - 1;
        if (drop) return 0;
        if (v > maxv) v = maxv;
        return (e != 0) ? maxv - v : v;
    endfunction

    function automatic exp_t model(int a, int b, logic [1:0] er, logic [1:0] kp,
                                   int n, int inw, string req);
        exp_t x;
        bit d0 = er[0] | ~kp[0];
        bit d1 = er[1] | ~kp[1];
        int maxv = (1 << n) - 1;
        for (int i = 0; i < 4; i++)
            x.m[i] = sdist(a, n, (i >> 1) & 1, d0) + sdist(b, n, i & 1, d1);
        x.flag = (inw > n) && ((!d0 && a > maxv) || (!d1 && b > maxv));
        x.req = req;
        return x;
    endfunction

    task automatic send_soft(int a, int b, logic [1:0] er, logic [1:0] kp, string req);
        exp_t x;
        @(negedge clk);
        s_iv = 1; s_s0 = 4'(a); s_s1 = 4'(b); s_er = er; s_kp = kp;
        x = model(a, b, er, kp, 3, 4, req);
        qs.push_back(x);
        for (int i = 0; i < 4; i++) last_soft[i] = x.m[i];
    endtask

    task automatic send_hard(int a, int b, logic [1:0] er, logic [1:0] kp);
        @(negedge clk);
        h_iv = 1; h_s0 = 1'(a); h_s1 = 1'(b); h_er = er; h_kp = kp;
        qh.push_back(model(a, b, er, kp, 1, 1, "R10"));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_iv = 0; h_iv = 0;
            s_s0 = 0; s_s1 = 0; s_er = 0; s_kp = 0;
            h_s0 = 0; h_s1 = 0; h_er = 0; h_kp = 0;
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Bench-side model of the one-cycle valid delay.
    always @(posedge clk) begin
        s_pend <= rst_n && s_iv;
        h_pend <= rst_n && h_iv;
    end

    // Soft monitor: valid timing, scoreboard compare, R9 balance.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            check(s_ov == s_pend, "R1", "soft out_valid", int'(s_ov), int'(s_pend));
            if (s_ov && qs.size() != 0) begin
                e = qs.pop_front();
                for (int i = 0; i < 4; i++)
                    check(int'(s_m[i]) == e.m[i], e.req, $sformatf("soft metric %0d", i),
                          int'(s_m[i]), e.m[i]);
                check(s_re == e.flag, "R6", "range_err", int'(s_re), int'(e.flag));
                check(int'(s_m[0]) + int'(s_m[3]) == int'(s_m[1]) + int'(s_m[2]),
                      "R9", "pair balance", int'(s_m[0]) + int'(s_m[3]),
                      int'(s_m[1]) + int'(s_m[2]));
            end
        end
    end

    // Hard monitor.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            check(h_ov == h_pend, "R1", "hard out_valid", int'(h_ov), int'(h_pend));
            if (h_ov && qh.size() != 0) begin
                e = qh.pop_front();
                for (int i = 0; i < 4; i++)
                    check(int'(h_m[i]) == e.m[i], "R10", $sformatf("hard metric %0d", i),
                          int'(h_m[i]), e.m[i]);
                check(h_re == 1'b0, "R6", "hard range_err", int'(h_re), 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state.
        check(s_ov == 0 && s_re == 0, "R8", "soft flags after reset", int'({s_ov, s_re}), 0);
        check(s_m == '0, "R8", "soft metrics after reset", int'(s_m), 0);
        check(h_ov == 0 && h_m == '0, "R8", "hard after reset", int'(h_m), 0);

        // R2 / R3: all in-range soft pairs, back to back.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                send_soft(a, b, 2'b00, 2'b11, "R2");
        send_soft(7, 7, 2'b00, 2'b11, "R3");
        send_soft(0, 0, 2'b00, 2'b11, "R3");
        idle(3);
        // R7: metrics held while idle.
        for (int i = 0; i < 4; i++)
            check(int'(s_m[i]) == last_soft[i], "R7", "held metric", int'(s_m[i]), last_soft[i]);
        check(s_ov == 0, "R7", "idle out_valid", int'(s_ov), 0);

        // R4: erasures; R5: punctured positions.
        for (int v = 0; v < 8; v++) begin
            send_soft(v, 7 - v, 2'b01, 2'b11, "R4");
            send_soft(v, 7 - v, 2'b10, 2'b11, "R4");
            send_soft(v, 3, 2'b11, 2'b11, "R4");
            send_soft(v, 7 - v, 2'b00, 2'b10, "R5");
            send_soft(v, 7 - v, 2'b00, 2'b01, "R5");
            send_soft(v, 5, 2'b00, 2'b00, "R5");
            idle(1);
        end

        // R6: oversize symbols, present and removed.
        for (int v = 6; v < 16; v++) begin
            send_soft(v, 2, 2'b00, 2'b11, "R6");
            send_soft(1, v, 2'b00, 2'b11, "R6");
            send_soft(v, v, 2'b01, 2'b11, "R6");
            send_soft(v, 15, 2'b00, 2'b00, "R6");
        end
        idle(2);

        // R10: hard decisions with masks.
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++) begin
                send_hard(a, b, 2'b00, 2'b11);
                send_hard(a, b, 2'b01, 2'b11);
                send_hard(a, b, 2'b00, 2'b01);
                idle(1);
            end
        idle(3);

        check(qs.size() == 0, "R1", "soft results outstanding", qs.size(), 0);
        check(qh.size() == 0, "R1", "hard results outstanding", qh.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule